// File: doc/BRIEF.md
# Exception cause priority selector

This block looks at the exception flags one instruction has raised and names the single cause that a trap should report. The flags arrive as a 24-bit vector, where bit n means that cause number n was raised. The block first restricts the vector to an allowed set of causes. It then picks the surviving cause that ranks highest in a fixed order. Purely combinational logic does both steps, so the answer is available in the same cycle as the flags.

A control bit chooses between two sets of allowed causes. In full mode, every architecturally defined cause survives. In fetch mode, only the causes that instruction fetch and decode can produce survive. The restricted vector is also brought out, so that downstream logic can record the flags it actually acted on.

Priority does not follow bit index. The order starts with breakpoint and fetch-side faults, then environment calls, then misaligned accesses, then page faults, guest page faults and access faults.

Top module: `exc_cause_select`

## Requirements
- R1: With `fetch_only_i` low, `exc_masked_o` equals `exc_vec_i` with every bit cleared except bits 0 through 13, bit 15 and bits 20 through 23.
- R2: With `fetch_only_i` high, `exc_masked_o` equals `exc_vec_i` with every bit cleared except bits 0, 1, 2, 12, 20 and 22.
- R3: `exc_valid_o` is high exactly when `exc_masked_o` has at least one bit set.
- R4: While `exc_valid_o` is low, `exc_cause_o` is zero.
- R5: When several masked bits are set, `exc_cause_o` is the one that comes first in this ranking, highest first: 3, 12, 20, 1, 2, 22, 0, 11, 9, 10, 8, 6, 4, 15, 13, 23, 21, 7, 5.
- R6: Bits 14 and 16 through 19 of `exc_vec_i` never affect `exc_valid_o` or `exc_cause_o`, in either mode.
- R7: When exactly one allowed bit n is set, `exc_valid_o` is high and `exc_cause_o` equals n.
- R8: In fetch mode, a raised breakpoint, environment call or data-side fault is ignored. With every input bit set, the result is cause 12.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| exc_vec_i | input | 24 | Raised exception flags, one bit per cause number |
| fetch_only_i | input | 1 | 1 allows only the fetch-side causes, 0 allows all defined causes |
| exc_valid_o | output | 1 | An allowed cause is pending |
| exc_cause_o | output | 5 | Number of the winning cause, zero when none is pending |
| exc_masked_o | output | 24 | Input vector after the allowed-set restriction |

## Verification
Every single-hot vector is applied in both modes. This shows that each cause maps to its own number, and it separates the allowed bits from the reserved bits and from the bits that fetch mode removes. Directed pairs such as 5 with 7 and 0 with 11 check the points where the ranking departs from index order. The all-ones vector checks the top of the ranking in each mode. Random multi-hot vectors in both modes are compared against a reference that walks the ranking list from the top, and they catch a misplaced rank that a single pair would miss.

// File: rtl/exc_cause_pkg.sv
package exc_cause_pkg;

  localparam int NUM_CAUSE = 24;
  localparam int CAUSE_W   = $clog2(NUM_CAUSE);
  localparam int NUM_RANK  = 19;
  localparam int NUM_FETCH = 6;

  typedef logic [CAUSE_W-1:0]   cause_t;
  typedef logic [NUM_CAUSE-1:0] cause_vec_t;

  // Ranking, strongest first; position in this list is the priority.
  localparam cause_t RANK_ORDER [NUM_RANK] = '{
    5'd3,  5'd12, 5'd20, 5'd1,  5'd2,  5'd22, 5'd0,
    5'd11, 5'd9,  5'd10, 5'd8,  5'd6,  5'd4,  5'd15,
    5'd13, 5'd23, 5'd21, 5'd7,  5'd5
  };

  // Causes that instruction fetch and decode can raise.
  localparam cause_t FETCH_SET [NUM_FETCH] = '{
    5'd0, 5'd1, 5'd2, 5'd12, 5'd20, 5'd22
  };

  function automatic cause_vec_t ranked_mask();
    cause_vec_t m = '0;
    for (int k = 0; k < NUM_RANK; k++) m[RANK_ORDER[k]] = 1'b1;
    return m;
  endfunction

  function automatic cause_vec_t fetch_mask();
    cause_vec_t m = '0;
    for (int k = 0; k < NUM_FETCH; k++) m[FETCH_SET[k]] = 1'b1;
    return m;
  endfunction

  localparam cause_vec_t FULL_KEEP  = ranked_mask();
  localparam cause_vec_t FETCH_KEEP = fetch_mask();

endpackage

// File: rtl/exc_subset_mask.sv
module exc_subset_mask
  import exc_cause_pkg::*;
#(
  parameter int VEC_W = NUM_CAUSE
) (
  input  logic [VEC_W-1:0] raw_i,
  input  logic             fetch_only_i,
  output logic [VEC_W-1:0] masked_o
);

  logic [VEC_W-1:0] keep_bits;

  assign keep_bits = fetch_only_i ? FETCH_KEEP[VEC_W-1:0] : FULL_KEEP[VEC_W-1:0];

  for (genvar b = 0; b < VEC_W; b++) begin : g_bit
    assign masked_o[b] = raw_i[b] & keep_bits[b];
  end

  always_comb begin
    AST_NO_NEW_BITS: assert ((masked_o & ~raw_i) == '0) else $error("mask set a bit not raised"); // R1
    AST_FETCH_CONFINED: assert (!fetch_only_i || ((masked_o & ~FETCH_KEEP[VEC_W-1:0]) == '0)) else $error("fetch mode leaked a cause"); // R2
    AST_RESERVED_CLEAR: assert ((masked_o & ~FULL_KEEP[VEC_W-1:0]) == '0) else $error("reserved bit survived"); // R6
  end

endmodule

// File: rtl/exc_rank_pick.sv
module exc_rank_pick
  import exc_cause_pkg::*;
#(
  parameter int VEC_W  = NUM_CAUSE,
  parameter int RANKS  = NUM_RANK,
  localparam int CW    = $clog2(VEC_W)
) (
  input  logic [VEC_W-1:0] vec_i,
  output logic             valid_o,
  output logic [CW-1:0]    cause_o
);

  logic [RANKS-1:0] hit_rank;
  logic [RANKS:0]   seen_above;
  logic [RANKS-1:0] win_rank;

  assign seen_above[0] = 1'b0;

  for (genvar k = 0; k < RANKS; k++) begin : g_rank
    assign hit_rank[k]     = vec_i[RANK_ORDER[k]];
    assign win_rank[k]     = hit_rank[k] & ~seen_above[k];
    assign seen_above[k+1] = seen_above[k] | hit_rank[k];
  end

  assign valid_o = seen_above[RANKS];

  always_comb begin
    cause_o = '0;
    for (int k = 0; k < RANKS; k++)
      cause_o = cause_o | ({CW{win_rank[k]}} & CW'(RANK_ORDER[k]));
  end

  always_comb begin
    AST_ONE_WINNER: assert ($onehot0(win_rank)) else $error("more than one rank won"); // R5
    AST_VALID_MATCH: assert (valid_o == (|(vec_i & FULL_KEEP[VEC_W-1:0]))) else $error("valid disagrees with input"); // R3
    AST_IDLE_ZERO: assert (valid_o || cause_o == '0) else $error("cause nonzero while idle"); // R4
    AST_WINNER_RAISED: assert (!valid_o || (int'(cause_o) < VEC_W && vec_i[cause_o])) else $error("chosen cause not raised"); // R5
  end

endmodule

// File: rtl/exc_cause_select.sv
module exc_cause_select
  import exc_cause_pkg::*;
(
  input  logic [23:0] exc_vec_i,
  input  logic        fetch_only_i,
  output logic        exc_valid_o,
  output logic [4:0]  exc_cause_o,
  output logic [23:0] exc_masked_o
);

  cause_vec_t masked_vec;
  logic       pick_valid;
  cause_t     pick_cause;

  exc_subset_mask #(.VEC_W(NUM_CAUSE)) u_mask (
    .raw_i        (exc_vec_i),
    .fetch_only_i (fetch_only_i),
    .masked_o     (masked_vec)
  );

  exc_rank_pick #(.VEC_W(NUM_CAUSE), .RANKS(NUM_RANK)) u_pick (
    .vec_i   (masked_vec),
    .valid_o (pick_valid),
    .cause_o (pick_cause)
  );

  assign exc_masked_o = masked_vec;
  assign exc_valid_o  = pick_valid;
  assign exc_cause_o  = pick_cause;

  always_comb begin
    AST_VALID_FROM_MASKED: assert (exc_valid_o == (exc_masked_o != '0)) else $error("valid vs masked mismatch"); // R3
    AST_FETCH_WINNER: assert (!(fetch_only_i && exc_valid_o) || FETCH_KEEP[exc_cause_o]) else $error("fetch mode chose a non-fetch cause"); // R8
  end

endmodule

// File: tb/test_exc_cause_select.sv
module test_exc_cause_select;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [23:0] vec;
  logic        fetch;
  logic        valid;
  logic [4:0]  cause;
  logic [23:0] masked;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_cause_select i_exc_cause_select (
    .exc_vec_i    (vec),
    .fetch_only_i (fetch),
    .exc_valid_o  (valid),
    .exc_cause_o  (cause),
    .exc_masked_o (masked)
  );

  // Ranking from the requirement, strongest first.
  function automatic int rank_at(input int p);
    case (p)
      0: return 3;   1: return 12;  2: return 20;  3: return 1;
      4: return 2;   5: return 22;  6: return 0;   7: return 11;
      8: return 9;   9: return 10;  10: return 8;  11: return 6;
      12: return 4;  13: return 15; 14: return 13; 15: return 23;
      16: return 21; 17: return 7;  default: return 5;
    endcase
  endfunction

  function automatic bit allowed(input int n, input bit f);
    if (f) return (n == 0 || n == 1 || n == 2 || n == 12 || n == 20 || n == 22);
    return (n <= 13 || n == 15 || n >= 20);
  endfunction

  function automatic logic [23:0] ref_mask(input logic [23:0] v, input bit f);
    logic [23:0] r = '0;
    for (int n = 0; n < 24; n++) if (allowed(n, f)) r[n] = v[n];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (vec=%06h fetch=%0b)", req, act, exp, vec, fetch);
    end
  endtask

  task automatic apply_and_check(input logic [23:0] v, input bit f, input string tag);
    logic [23:0] em;
    int ec;
    bit ev;
    vec = v; fetch = f;
    @(negedge clk);
    em = ref_mask(v, f);
    ev = 1'b0; ec = 0;
    for (int p = 0; p < 19; p++) begin
      if (!ev && em[rank_at(p)]) begin ev = 1'b1; ec = rank_at(p); end
    end
    chk(masked == em, f ? "R2" : "R1", int'(masked), int'(em));
    chk(valid == ev, "R3", int'(valid), int'(ev));
    chk(int'(cause) == ec, ev ? tag : "R4", int'(cause), ec);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [23:0] rv;
    vec = '0; fetch = 1'b0;
    // reset state: nothing raised
    apply_and_check(24'h0, 1'b0, "R4");
    apply_and_check(24'h0, 1'b1, "R4");
    // single-hot in both modes (R7)
    for (int n = 0; n < 24; n++) begin
      apply_and_check(24'h1 << n, 1'b0, "R7");
      apply_and_check(24'h1 << n, 1'b1, "R7");
    end
    // reserved bits only: no effect (R6)
    apply_and_check(24'h0F4000, 1'b0, "R6");
    chk(valid == 1'b0, "R6", int'(valid), 0);
    apply_and_check(24'h0F4000 | 24'h000020, 1'b0, "R6");
    chk(cause == 5'd5, "R6", int'(cause), 5);
    // order departs from index (R5)
    apply_and_check(24'h0000A0, 1'b0, "R5");
    chk(cause == 5'd7, "R5", int'(cause), 7);
    apply_and_check(24'h000801, 1'b0, "R5");
    chk(cause == 5'd0, "R5", int'(cause), 0);
    apply_and_check(24'h100002, 1'b0, "R5");
    chk(cause == 5'd20, "R5", int'(cause), 20);
    // all ones
    apply_and_check(24'hFFFFFF, 1'b0, "R5");
    chk(cause == 5'd3, "R5", int'(cause), 3);
    apply_and_check(24'hFFFFFF, 1'b1, "R8");
    chk(cause == 5'd12, "R8", int'(cause), 12);
    // fetch mode ignores breakpoint, ecalls, data faults
    apply_and_check(24'hA0EFF8 & ~24'h501007, 1'b1, "R8");
    chk(valid == 1'b0, "R8", int'(valid), 0);
    // random multi-hot
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < 3000; i++) begin
      rv = 24'($urandom()) & 24'($urandom());
      apply_and_check(rv, i[0], "R5");
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule